// File: doc/BRIEF.md
# Bus Turnaround and Response Timer

This block times the idle gap between packets on a serial bus link endpoint that runs either at low/full speed or at high speed. It watches four line events: the end of a received packet, the end of a locally sent packet, the start of a received packet and the start of a locally sent packet. It keeps one count of the half-bit periods that have passed since the most recent end-of-packet. A clock prescaler turns system clocks into half-bit ticks for the selected data rate. Counting in half bits lets the fractional reply deadlines be compared exactly.

Three outputs come from that count. A transmit qualifier holds a pending local transmit request back until the minimum gap for the situation has passed. A local reply to a received packet needs a shorter gap than a second local packet sent straight after the first. The second output is a one-cycle timeout pulse when a reply that was expected after a local transmission never starts. The third is a one-cycle flag when a local reply starts later than the allowed turnaround. An upstream protocol layer decides whether a packet calls for a reply and says so through `expect_resp_i`, which is sampled together with each end-of-packet event.

Top module: `bus_turnaround_timer`

## Requirements
- R1: After reset the line is idle, no gap is pending and no timer is armed: `tx_allow_o` equals `tx_req_i`, and `resp_timeout_o` and `late_reply_o` are 0.
- R2: In low/full-speed mode (`hs_mode_i`=0), after either end-of-packet event `tx_allow_o` stays 0 until 4 half-bit periods (2 bit times) have elapsed. With a prescale of 2 clocks per half bit, it is 0 for 7 cycles after the event edge and 1 on the 8th.
- R3: In high-speed mode, after a received end-of-packet `tx_allow_o` stays 0 until 16 half-bit periods (8 bit times) have elapsed.
- R4: In high-speed mode, after a local end-of-packet the minimum gap is 176 half-bit periods (88 bit times) when `host_role_i`=1 and 16 half-bit periods when `host_role_i`=0.
- R5: Between a start-of-packet event and the next end-of-packet event the line is busy and `tx_allow_o` is 0, whatever the elapsed count.
- R6: In low/full-speed mode, a local end-of-packet sampled with `expect_resp_i`=1 arms the timer. If no received start-of-packet arrives, `resp_timeout_o` rises in the cycle in which 34 half-bit periods (17 bit times) have elapsed. This lies inside the 16 to 18 bit window.
- R7: In high-speed mode the armed timer fires once 1552 half-bit periods (776 bit times) have elapsed. This lies inside the 736 to 816 bit window.
- R8: A received start-of-packet while the timer is armed disarms it. No timeout follows, and a pulse due in that same cycle is suppressed.
- R9: A local end-of-packet sampled with `expect_resp_i`=0 leaves the timer disarmed, and no timeout pulse follows.
- R10: In low/full-speed mode, a received end-of-packet sampled with `expect_resp_i`=1 opens a reply obligation. A local start-of-packet sampled when more than 13 (device, `host_role_i`=0) or more than 15 (host) half-bit periods have elapsed raises `late_reply_o` for one cycle, in the cycle after that start. At or below the limit it stays 0.
- R11: In high-speed mode the reply limit is 384 half-bit periods (192 bit times). A received end-of-packet sampled with `expect_resp_i`=0 opens no obligation, and a late local start then raises no flag.
- R12: `resp_timeout_o` is a single-cycle pulse, and the timer is disarmed after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_mode_i | input | 1 | 1 selects high-speed rules and prescale, 0 low/full speed |
| host_role_i | input | 1 | 1 when this endpoint is the host |
| eop_rx_i | input | 1 | One-cycle event: a received packet has ended and the line is idle |
| eop_tx_i | input | 1 | One-cycle event: a locally sent packet has ended |
| sop_rx_i | input | 1 | One-cycle event: a received packet has started |
| sop_tx_i | input | 1 | One-cycle event: a local packet has started on the line |
| expect_resp_i | input | 1 | Sampled with either end-of-packet event: that packet calls for a reply |
| tx_req_i | input | 1 | Local logic wants to start a packet |
| tx_allow_o | output | 1 | Transmit qualifier: request present, line idle, minimum gap met |
| resp_timeout_o | output | 1 | One-cycle pulse: expected reply did not start in time |
| late_reply_o | output | 1 | One-cycle flag: a local reply started past the turnaround limit |

## Verification
The transmit qualifier is driven after a received end and after a local end, in both speed modes and both roles. This separates the reply gap from the back-to-back gap, and the 88-bit host rule from the 8-bit device rule. It is also checked while a packet is in progress, which shows that the busy state overrides a satisfied gap count. The timeout is driven armed and unarmed and with a received start inside the window, and the exact firing cycle is checked one cycle on each side. Local replies are started one half-bit period on each side of the device, host and high-speed limits, which pins each comparison to strictly-greater-than, and once with no reply owed.

// File: rtl/btt_pkg.sv
package btt_pkg;

    // All limits are counted in half-bit periods of the current data rate.
    localparam int HB_FS_MIN_GAP    = 4;     // 2 bit times
    localparam int HB_HS_REPLY_GAP  = 16;    // 8 bit times
    localparam int HB_HS_B2B_GAP    = 176;   // 88 bit times
    localparam int HB_FS_DEV_MAX    = 13;    // 6.5 bit times
    localparam int HB_FS_HOST_MAX   = 15;    // 7.5 bit times
    localparam int HB_HS_REPLY_MAX  = 384;   // 192 bit times
    localparam int HB_FS_TIMEOUT    = 34;    // 17 bit times
    localparam int HB_HS_TIMEOUT    = 1552;  // 776 bit times
    localparam int HB_FS_TO_FLOOR   = 32;    // 16 bit times, earliest legal
    localparam int HB_HS_TO_FLOOR   = 1472;  // 736 bit times, earliest legal

    localparam int GAP_W = $clog2(HB_HS_TIMEOUT + 2);

    typedef logic [GAP_W-1:0] gap_t;

    typedef enum logic [1:0] {
        CTX_NONE  = 2'd0,
        CTX_REPLY = 2'd1,
        CTX_B2B   = 2'd2
    } gap_ctx_e;

    typedef struct packed {
        gap_t min_gap;
        gap_t reply_max;
        gap_t timeout;
    } limits_t;

    function automatic limits_t pick_limits(logic hs, logic host, gap_ctx_e ctx);
        limits_t lim;
        if (ctx == CTX_NONE) begin
            lim.min_gap = '0;
        end else if (hs) begin
            lim.min_gap = (ctx == CTX_B2B && host) ? gap_t'(HB_HS_B2B_GAP)
                                                   : gap_t'(HB_HS_REPLY_GAP);
        end else begin
            lim.min_gap = gap_t'(HB_FS_MIN_GAP);
        end
        if (hs)
            lim.reply_max = gap_t'(HB_HS_REPLY_MAX);
        else
            lim.reply_max = host ? gap_t'(HB_FS_HOST_MAX) : gap_t'(HB_FS_DEV_MAX);
        lim.timeout = hs ? gap_t'(HB_HS_TIMEOUT) : gap_t'(HB_FS_TIMEOUT);
        return lim;
    endfunction

    function automatic gap_t timeout_floor(logic hs);
        return hs ? gap_t'(HB_HS_TO_FLOOR) : gap_t'(HB_FS_TO_FLOOR);
    endfunction

endpackage

// File: rtl/btt_halfbit_tick.sv
module btt_halfbit_tick #(
    parameter int DIV_FS = 2,
    parameter int DIV_HS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic hs,
    input  logic restart,
    output logic tick
);
    localparam int DMAX = (DIV_FS > DIV_HS) ? DIV_FS : DIV_HS;
    localparam int PW   = (DMAX > 1) ? $clog2(DMAX) : 1;

    generate
        if (DIV_FS == 1 && DIV_HS == 1) begin : g_direct
            logic unused_in;
            assign unused_in = clk ^ rst ^ hs;
            assign tick = !restart;
        end else begin : g_count
            logic [PW-1:0] cnt_q;
            logic [PW-1:0] lim;

            assign lim  = hs ? PW'(DIV_HS - 1) : PW'(DIV_FS - 1);
            assign tick = !restart && (cnt_q >= lim);

            always_ff @(posedge clk) begin
                if (rst || restart)
                    cnt_q <= '0;
                else if (cnt_q >= lim)
                    cnt_q <= '0;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/btt_gap_track.sv
module btt_gap_track
    import btt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     eop_rx,
    input  logic     eop_tx,
    input  logic     sop_rx,
    input  logic     sop_tx,
    output gap_t     gap_q,
    output gap_ctx_e ctx_q,
    output logic     idle_q
);
    logic any_eop;
    assign any_eop = eop_rx || eop_tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '1;
            ctx_q  <= CTX_NONE;
            idle_q <= 1'b1;
        end else begin
            if (any_eop)
                gap_q <= '0;
            else if (tick && gap_q != '1)
                gap_q <= gap_q + 1'b1;

            if (eop_rx)
                ctx_q <= CTX_REPLY;
            else if (eop_tx)
                ctx_q <= CTX_B2B;

            if (any_eop)
                idle_q <= 1'b1;
            else if (sop_rx || sop_tx)
                idle_q <= 1'b0;
        end
    end

endmodule

// File: rtl/btt_resp_watch.sv
module btt_resp_watch
    import btt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic eop_tx,
    input  logic expect_resp,
    input  logic sop_rx,
    input  gap_t gap,
    input  gap_t to_lim,
    output logic timeout
);
    logic armed_q;

    assign timeout = armed_q && (gap >= to_lim) && !sop_rx && !eop_tx;

    always_ff @(posedge clk) begin
        if (rst)
            armed_q <= 1'b0;
        else if (eop_tx)
            armed_q <= expect_resp;
        else if (sop_rx || timeout)
            armed_q <= 1'b0;
    end

    AST_TO_DISARMS: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !armed_q); // R12

endmodule

// File: rtl/btt_reply_check.sv
module btt_reply_check
    import btt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic eop_rx,
    input  logic eop_tx,
    input  logic expect_resp,
    input  logic sop_rx,
    input  logic sop_tx,
    input  gap_t gap,
    input  gap_t reply_max,
    output logic late_q
);
    logic owe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            owe_q  <= 1'b0;
            late_q <= 1'b0;
        end else begin
            late_q <= owe_q && sop_tx && (gap > reply_max);
            if (eop_rx)
                owe_q <= expect_resp;
            else if (sop_tx || sop_rx || eop_tx)
                owe_q <= 1'b0;
        end
    end

    AST_LATE_FROM_SOP: assert property (@(posedge clk) disable iff (rst)
        late_q |-> $past(sop_tx)); // R10

endmodule

// File: rtl/bus_turnaround_timer.sv
module bus_turnaround_timer
    import btt_pkg::*;
#(
    parameter int HALF_DIV_FS = 2,
    parameter int HALF_DIV_HS = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic hs_mode_i,
    input  logic host_role_i,
    input  logic eop_rx_i,
    input  logic eop_tx_i,
    input  logic sop_rx_i,
    input  logic sop_tx_i,
    input  logic expect_resp_i,
    input  logic tx_req_i,
    output logic tx_allow_o,
    output logic resp_timeout_o,
    output logic late_reply_o
);
    logic     tick;
    gap_t     gap_cnt;
    gap_ctx_e ctx;
    logic     line_idle;
    limits_t  lims;

    btt_halfbit_tick #(
        .DIV_FS (HALF_DIV_FS),
        .DIV_HS (HALF_DIV_HS)
    ) u_tick (
        .clk     (clk),
        .rst     (rst),
        .hs      (hs_mode_i),
        .restart (eop_rx_i || eop_tx_i),
        .tick    (tick)
    );

    btt_gap_track u_track (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .eop_rx (eop_rx_i),
        .eop_tx (eop_tx_i),
        .sop_rx (sop_rx_i),
        .sop_tx (sop_tx_i),
        .gap_q  (gap_cnt),
        .ctx_q  (ctx),
        .idle_q (line_idle)
    );

    assign lims = pick_limits(hs_mode_i, host_role_i, ctx);

    btt_resp_watch u_watch (
        .clk         (clk),
        .rst         (rst),
        .eop_tx      (eop_tx_i),
        .expect_resp (expect_resp_i),
        .sop_rx      (sop_rx_i),
        .gap         (gap_cnt),
        .to_lim      (lims.timeout),
        .timeout     (resp_timeout_o)
    );

    btt_reply_check u_reply (
        .clk         (clk),
        .rst         (rst),
        .eop_rx      (eop_rx_i),
        .eop_tx      (eop_tx_i),
        .expect_resp (expect_resp_i),
        .sop_rx      (sop_rx_i),
        .sop_tx      (sop_tx_i),
        .gap         (gap_cnt),
        .reply_max   (lims.reply_max),
        .late_q      (late_reply_o)
    );

    assign tx_allow_o = tx_req_i && line_idle && (gap_cnt >= lims.min_gap);

    AST_EOP_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
        (eop_rx_i || eop_tx_i) |=> !tx_allow_o); // R2

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        ((sop_rx_i || sop_tx_i) && !eop_rx_i && !eop_tx_i) |=> !tx_allow_o); // R5

    AST_TO_ABOVE_FLOOR: assert property (@(posedge clk) disable iff (rst)
        resp_timeout_o |-> (gap_cnt >= timeout_floor(hs_mode_i))); // R6

    AST_TO_NOT_ON_SOP: assert property (@(posedge clk) disable iff (rst)
        resp_timeout_o |-> !sop_rx_i); // R8

    AST_TO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        resp_timeout_o |=> !resp_timeout_o); // R12

endmodule

// File: tb/bus_turnaround_timer_bench.sv
module bus_turnaround_timer_bench;

    localparam int SIG_ALLOW = 0;
    localparam int SIG_TO    = 1;
    localparam int SIG_LATE  = 2;
    localparam int EV_EOPRX  = 0;
    localparam int EV_EOPTX  = 1;
    localparam int EV_SOPRX  = 2;
    localparam int EV_SOPTX  = 3;

    typedef struct {
        int    cyc;
        int    sig;
        bit    val;
        string req;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hs_mode = 1'b0, host_role = 1'b0;
    logic eop_rx = 1'b0, eop_tx = 1'b0, sop_rx = 1'b0, sop_tx = 1'b0;
    logic expect_resp = 1'b0, tx_req = 1'b1;
    logic tx_allow, resp_timeout, late_reply;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    item_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    bus_turnaround_timer u_bus_turnaround_timer (
        .clk            (clk),
        .rst            (rst),
        .hs_mode_i      (hs_mode),
        .host_role_i    (host_role),
        .eop_rx_i       (eop_rx),
        .eop_tx_i       (eop_tx),
        .sop_rx_i       (sop_rx),
        .sop_tx_i       (sop_tx),
        .expect_resp_i  (expect_resp),
        .tx_req_i       (tx_req),
        .tx_allow_o     (tx_allow),
        .resp_timeout_o (resp_timeout),
        .late_reply_o   (late_reply)
    );

    function automatic bit observe(int sig);
        case (sig)
            SIG_ALLOW: return tx_allow;
            SIG_TO:    return resp_timeout;
            default:   return late_reply;
        endcase
    endfunction

    function automatic string sig_name(int sig);
        case (sig)
            SIG_ALLOW: return "tx_allow";
            SIG_TO:    return "resp_timeout";
            default:   return "late_reply";
        endcase
    endfunction

    task automatic push(input int c, input int sig, input bit val, input string req);
        item_t it;
        int pos;
        it.cyc = c; it.sig = sig; it.val = val; it.req = req;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].cyc > c) begin
                pos = i;
                break;
            end
        end
        q.insert(pos, it);
    endtask

    task automatic set_ev(input int which, input logic v);
        case (which)
            EV_EOPRX: eop_rx = v;
            EV_EOPTX: eop_tx = v;
            EV_SOPRX: sop_rx = v;
            default:  sop_tx = v;
        endcase
    endtask

    // Event sampled at posedge number at_edge; returns that edge number.
    task automatic fire(input int which, input bit exp, input int at_edge, output int edge_o);
        while (cyc < at_edge - 1) @(negedge clk);
        set_ev(which, 1'b1);
        expect_resp = exp;
        @(negedge clk);
        set_ev(which, 1'b0);
        expect_resp = 1'b0;
        edge_o = cyc;
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops due items and compares against the ports.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                item_t it;
                bit act;
                it = q.pop_front();
                checks++;
                act = observe(it.sig);
                if (it.cyc < cyc) begin
                    failures++;
                    $display("FAIL %s %s missed cycle %0d actual=late expected=%0b",
                             it.req, sig_name(it.sig), it.cyc, it.val);
                end else if (act !== it.val) begin
                    failures++;
                    $display("FAIL %s %s cycle %0d actual=%0b expected=%0b",
                             it.req, sig_name(it.sig), cyc, act, it.val);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int e;
        int s;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        push(cyc, SIG_ALLOW, 1'b1, "R1");
        push(cyc, SIG_TO, 1'b0, "R1");
        push(cyc, SIG_LATE, 1'b0, "R1");
        @(negedge clk);
        tx_req = 1'b0;
        push(cyc, SIG_ALLOW, 1'b0, "R1");
        @(negedge clk);
        tx_req = 1'b1;
        drain();

        // R2: low/full-speed two-bit minimum gap, after either end event
        fire(EV_EOPRX, 1'b0, cyc + 1, e);
        push(e, SIG_ALLOW, 1'b0, "R2");
        push(e + 7, SIG_ALLOW, 1'b0, "R2");
        push(e + 8, SIG_ALLOW, 1'b1, "R2");
        drain();
        fire(EV_EOPTX, 1'b0, cyc + 1, e);
        push(e + 7, SIG_ALLOW, 1'b0, "R2");
        push(e + 8, SIG_ALLOW, 1'b1, "R2");
        drain();

        // R3: high-speed reply gap
        hs_mode = 1'b1;
        fire(EV_EOPRX, 1'b0, cyc + 1, e);
        push(e + 15, SIG_ALLOW, 1'b0, "R3");
        push(e + 16, SIG_ALLOW, 1'b1, "R3");
        drain();

        // R4: high-speed back-to-back, host then device
        host_role = 1'b1;
        fire(EV_EOPTX, 1'b0, cyc + 1, e);
        push(e + 16, SIG_ALLOW, 1'b0, "R4");
        push(e + 175, SIG_ALLOW, 1'b0, "R4");
        push(e + 176, SIG_ALLOW, 1'b1, "R4");
        drain();
        host_role = 1'b0;
        fire(EV_EOPTX, 1'b0, cyc + 1, e);
        push(e + 15, SIG_ALLOW, 1'b0, "R4");
        push(e + 16, SIG_ALLOW, 1'b1, "R4");
        drain();

        // R5: busy line blocks transmit
        fire(EV_SOPRX, 1'b0, cyc + 1, e);
        push(e, SIG_ALLOW, 1'b0, "R5");
        push(e + 50, SIG_ALLOW, 1'b0, "R5");
        drain();
        fire(EV_EOPRX, 1'b0, cyc + 1, e);
        push(e + 16, SIG_ALLOW, 1'b1, "R5");
        drain();

        // R6 / R12: low/full-speed timeout
        hs_mode = 1'b0;
        fire(EV_EOPTX, 1'b1, cyc + 1, e);
        push(e + 67, SIG_TO, 1'b0, "R6");
        push(e + 68, SIG_TO, 1'b1, "R6");
        push(e + 69, SIG_TO, 1'b0, "R12");
        push(e + 80, SIG_TO, 1'b0, "R12");
        drain();

        // R7: high-speed timeout
        hs_mode = 1'b1;
        fire(EV_EOPTX, 1'b1, cyc + 1, e);
        push(e + 1551, SIG_TO, 1'b0, "R7");
        push(e + 1552, SIG_TO, 1'b1, "R7");
        push(e + 1553, SIG_TO, 1'b0, "R12");
        drain();

        // R8: received start cancels the timer
        hs_mode = 1'b0;
        fire(EV_EOPTX, 1'b1, cyc + 1, e);
        fire(EV_SOPRX, 1'b0, e + 40, s);
        push(e + 68, SIG_TO, 1'b0, "R8");
        push(e + 69, SIG_TO, 1'b0, "R8");
        drain();
        fire(EV_EOPRX, 1'b0, cyc + 1, e);
        drain();

        // R9: no reply expected, no timeout
        fire(EV_EOPTX, 1'b0, cyc + 1, e);
        push(e + 68, SIG_TO, 1'b0, "R9");
        push(e + 69, SIG_TO, 1'b0, "R9");
        drain();

        // R10: low/full-speed reply deadline, device then host
        fire(EV_EOPRX, 1'b1, cyc + 1, e);
        fire(EV_SOPTX, 1'b0, e + 28, s);
        push(s, SIG_LATE, 1'b0, "R10");
        drain();
        fire(EV_EOPTX, 1'b0, cyc + 1, e);
        fire(EV_EOPRX, 1'b1, cyc + 1, e);
        fire(EV_SOPTX, 1'b0, e + 29, s);
        push(s, SIG_LATE, 1'b1, "R10");
        push(s + 1, SIG_LATE, 1'b0, "R10");
        drain();
        fire(EV_EOPTX, 1'b0, cyc + 1, e);
        host_role = 1'b1;
        fire(EV_EOPRX, 1'b1, cyc + 1, e);
        fire(EV_SOPTX, 1'b0, e + 32, s);
        push(s, SIG_LATE, 1'b0, "R10");
        drain();
        fire(EV_EOPTX, 1'b0, cyc + 1, e);
        fire(EV_EOPRX, 1'b1, cyc + 1, e);
        fire(EV_SOPTX, 1'b0, e + 33, s);
        push(s, SIG_LATE, 1'b1, "R10");
        drain();
        fire(EV_EOPTX, 1'b0, cyc + 1, e);
        host_role = 1'b0;

        // R11: high-speed reply deadline and no-obligation case
        hs_mode = 1'b1;
        fire(EV_EOPRX, 1'b1, cyc + 1, e);
        fire(EV_SOPTX, 1'b0, e + 385, s);
        push(s, SIG_LATE, 1'b0, "R11");
        drain();
        fire(EV_EOPTX, 1'b0, cyc + 1, e);
        fire(EV_EOPRX, 1'b1, cyc + 1, e);
        fire(EV_SOPTX, 1'b0, e + 386, s);
        push(s, SIG_LATE, 1'b1, "R11");
        push(s + 1, SIG_LATE, 1'b0, "R11");
        drain();
        fire(EV_EOPTX, 1'b0, cyc + 1, e);
        fire(EV_EOPRX, 1'b0, cyc + 1, e);
        fire(EV_SOPTX, 1'b0, e + 500, s);
        push(s, SIG_LATE, 1'b0, "R11");
        drain();
        fire(EV_EOPTX, 1'b0, cyc + 1, e);
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule